// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller serving four banks of 32 pins each, 128 lines in all. Software chooses, pin by pin, whether the line is driven or only observed, sets and clears output values with write-one operations, and reads the synchronized pin levels back through a small register bus.

Every pin can also raise an interrupt, on a rising edge, a falling edge, or both, through two independent enable bits. An enabled edge latches a sticky status bit that stays set until software writes a one to it. A per-pin mask gates the status bits. Every unmasked status bit in every bank is merged onto one interrupt line. There is no level-triggered mode: a pin that holds still never interrupts.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, gpio_out and gpio_oe are all zero, every enable and status bit is zero, every mask bit is one (a mask word reads 0xFFFFFFFF), and irq is low.
- R2: Bank n occupies byte offsets n*0x100 to n*0x100+0x1C. Byte address bits [1:0] are ignored. Word offsets 0 to 7 within a bank are: level (read-only), direction, output set, output clear, rising enable, falling enable, status, mask.
- R3: A direction bit of 1 makes the matching gpio_oe bit 1, and a 0 makes it 0. The direction word reads back as written.
- R4: Writing to output set (offset 2) sets each gpio_out bit whose data bit is 1. Writing to output clear (offset 3) clears each bit whose data bit is 1. Other bits, including those of other banks, keep their value. Both offsets read back the bank's current output value.
- R5: The level word returns gpio_in after a two-flop synchronizer. A change made before clock edge k is visible to a read captured at edge k+2 or later.
- R6: With its rising enable set, a 0-to-1 transition of the synchronized pin sets the pin's status bit. With its falling enable set, a 1-to-0 transition sets it. With both set, either transition sets it.
- R7: A transition whose edge type is not enabled, or a pin that holds its level, leaves the status bit at 0.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. When an enabled edge is detected in the same cycle as the clearing write, the bit stays set.
- R9: irq is high exactly while some status bit in any bank has its mask bit at 0. Masking a pin does not clear its status bit.
- R10: Word offsets 8 and above inside a bank, and banks at index 4 and above, read as zero. Writes to them change no register.
- R11: A transfer is presented with req high for one cycle. A write takes effect at that clock edge. On the next cycle ready is high and rdata carries the read data. When no read is completing, ready is low and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 11 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with ready |
| ready | output | 1 | Transfer completion, one cycle after req |
| gpio_in | input | 128 | Pin input levels, asynchronous |
| gpio_out | output | 128 | Pin output values |
| gpio_oe | output | 128 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded assertions check on every cycle that a status bit never appears without a transition on the synchronized pin, that it never drops without a clearing write, that it clears when that write meets no edge, that a set write always shows on gpio_out, and that irq stays low while every pin is masked. The bench scenarios are needed for the rest. They cover the address map and read-back values, synchronizer latency, the choice among edge types, the edge that coincides with its own clear, and the inert holes in the window, none of which a single-cycle property can see in full.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NBANKS = 4,
  parameter int DW     = 32,
  parameter int ADDR_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 ready,
  input  logic [NBANKS*DW-1:0] gpio_in,
  output logic [NBANKS*DW-1:0] gpio_out,
  output logic [NBANKS*DW-1:0] gpio_oe,
  output logic                 irq
);
  localparam int NP     = NBANKS * DW;
  localparam int BSH    = 8;
  localparam int WSH    = 2;
  localparam int BIDX_W = ADDR_W - BSH;

  logic [NP-1:0] s1, s2, s3;
  logic [NP-1:0] dout, dir, ren, fen, stat, mask;
  logic [NP-1:0] set_v, oclr_v, sclr_v, hit;
  logic [DW-1:0] rd_bank [NBANKS];
  logic [DW-1:0] rd;

  wire [BIDX_W-1:0] bidx    = addr[ADDR_W-1:BSH];
  wire [2:0]        off     = addr[WSH+2:WSH];
  wire              in_bank = (addr[BSH-1:WSH+3] == '0);

  assign hit      = (s2 & ~s3 & ren) | (~s2 & s3 & fen);
  assign gpio_out = dout;
  assign gpio_oe  = dir;
  assign irq      = |(stat & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      s3   <= '0;
      dout <= '0;
      stat <= '0;
    end else begin
      s1   <= gpio_in;
      s2   <= s1;
      s3   <= s2;
      dout <= (dout | set_v) & ~oclr_v;
      stat <= (stat & ~sclr_v) | hit;
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    wire hb = req && in_bank && (bidx == BIDX_W'(b));
    wire wb = hb && we;

    assign set_v [b*DW +: DW] = (wb && off == 3'd2) ? wdata : '0;
    assign oclr_v[b*DW +: DW] = (wb && off == 3'd3) ? wdata : '0;
    assign sclr_v[b*DW +: DW] = (wb && off == 3'd6) ? wdata : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir [b*DW +: DW] <= '0;
        ren [b*DW +: DW] <= '0;
        fen [b*DW +: DW] <= '0;
        mask[b*DW +: DW] <= '1;
      end else if (wb) begin
        case (off)
          3'd1: dir [b*DW +: DW] <= wdata;
          3'd4: ren [b*DW +: DW] <= wdata;
          3'd5: fen [b*DW +: DW] <= wdata;
          3'd7: mask[b*DW +: DW] <= wdata;
          default: ;
        endcase
      end
    end

    always_comb begin
      rd_bank[b] = '0;
      if (hb) begin
        case (off)
          3'd0:         rd_bank[b] = s2  [b*DW +: DW];
          3'd1:         rd_bank[b] = dir [b*DW +: DW];
          3'd2, 3'd3:   rd_bank[b] = dout[b*DW +: DW];
          3'd4:         rd_bank[b] = ren [b*DW +: DW];
          3'd5:         rd_bank[b] = fen [b*DW +: DW];
          3'd6:         rd_bank[b] = stat[b*DW +: DW];
          default:      rd_bank[b] = mask[b*DW +: DW];
        endcase
      end
    end
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < NBANKS; i++) rd = rd | rd_bank[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= req;
      rdata <= (req && !we) ? rd : '0;
    end
  end

  // R7
  no_spurious_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2 == s3) |=> ((stat & ~$past(stat)) == '0));

  // R8
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~$past(sclr_v) & ~stat) == '0));

  // R8
  w1c_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & $past(sclr_v & ~hit)) == '0));

  // R4
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_out & $past(set_v)) == $past(set_v)));

  // R9
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [10:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         ready;
  logic [127:0] gpio_in = '0;
  logic [127:0] gpio_out, gpio_oe;
  logic         irq;
  int           n_chk = 0, n_bad = 0;
  logic [31:0]  r;

  always #5 clk = ~clk;

  gpio_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
    check("R11 ready with read data", {31'b0, ready}, 32'd1);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 gpio_out", gpio_out[31:0] | gpio_out[127:96], 32'h0);
    check("R1 gpio_oe", gpio_oe[63:32] | gpio_oe[95:64], 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(11'h01C, r); check("R1 mask bank0", r, 32'hFFFF_FFFF);
    rd(11'h218, r); check("R1 status bank2", r, 32'h0);
    wait_n(1);
    check("R11 idle ready", {31'b0, ready}, 32'h0);
    check("R11 idle rdata", rdata, 32'h0);
  endtask

  task automatic t_dir();
    wr(11'h104, 32'h0000_FF00);
    check("R3 gpio_oe bank1", gpio_oe[63:32], 32'h0000_FF00);
    check("R3 gpio_oe bank0", gpio_oe[31:0], 32'h0);
    rd(11'h105, r); check("R2 R3 dir readback, low bits ignored", r, 32'h0000_FF00);
  endtask

  task automatic t_out();
    wr(11'h208, 32'h0000_00A5);
    check("R4 set", gpio_out[95:64], 32'h0000_00A5);
    wr(11'h20C, 32'h0000_0005);
    check("R4 clear", gpio_out[95:64], 32'h0000_00A0);
    check("R4 other bank", gpio_out[127:96], 32'h0);
    rd(11'h208, r); check("R4 read set offset", r, 32'h0000_00A0);
    rd(11'h20C, r); check("R4 read clear offset", r, 32'h0000_00A0);
  endtask

  task automatic t_level();
    gpio_in[127:96] = 32'h1234_5678;
    wait_n(3);
    rd(11'h300, r); check("R5 level bank3", r, 32'h1234_5678);
    rd(11'h000, r); check("R2 level bank0", r, 32'h0);
    gpio_in[127:96] = 32'h0;
    wait_n(3);
  endtask

  task automatic t_edges();
    wr(11'h01C, 32'hFFFF_FFF7);
    wr(11'h010, 32'h0000_0008);
    gpio_in[3] = 1'b1; wait_n(4);
    rd(11'h018, r); check("R6 rising sets status", r, 32'h8);
    check("R9 irq on unmasked status", {31'b0, irq}, 32'h1);
    wr(11'h018, 32'h8);
    check("R8 w1c clears", {31'b0, irq}, 32'h0);
    gpio_in[3] = 1'b0; wait_n(4);
    rd(11'h018, r); check("R7 falling ignored with rise only", r, 32'h0);
    wait_n(20);
    rd(11'h018, r); check("R7 steady level no status", r, 32'h0);
    wr(11'h014, 32'h0000_0008);
    gpio_in[3] = 1'b1; wait_n(4);
    rd(11'h018, r); check("R6 both: rising", r, 32'h8);
    wr(11'h018, 32'h0);
    rd(11'h018, r); check("R8 write 0 keeps status", r, 32'h8);
    wr(11'h018, 32'h8);
    gpio_in[3] = 1'b0; wait_n(4);
    rd(11'h018, r); check("R6 both: falling", r, 32'h8);
  endtask

  task automatic t_clear_race();
    gpio_in[3] = 1'b1;
    wait_n(2);
    wr(11'h018, 32'h8);
    rd(11'h018, r); check("R8 edge wins over same-cycle clear", r, 32'h8);
    wr(11'h018, 32'h8);
    rd(11'h018, r); check("R8 later clear works", r, 32'h0);
  endtask

  task automatic t_mask();
    wr(11'h310, 32'h8000_0000);
    wr(11'h31C, 32'h7FFF_FFFF);
    gpio_in[127] = 1'b1; wait_n(4);
    check("R9 bank3 drives irq", {31'b0, irq}, 32'h1);
    wr(11'h31C, 32'hFFFF_FFFF);
    check("R9 masked irq low", {31'b0, irq}, 32'h0);
    rd(11'h318, r); check("R9 mask keeps status", r, 32'h8000_0000);
  endtask

  task automatic t_holes();
    wr(11'h020, 32'hFFFF_FFFF);
    wr(11'h404, 32'hFFFF_FFFF);
    rd(11'h004, r); check("R10 dir bank0 untouched", r, 32'h0);
    check("R10 gpio_oe untouched", gpio_oe[31:0], 32'h0);
    rd(11'h020, r); check("R10 offset 8 reads zero", r, 32'h0);
    rd(11'h404, r); check("R10 bank4 reads zero", r, 32'h0);
    rd(11'h104, r); check("R10 dir bank1 untouched", r, 32'h0000_FF00);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_dir();
    t_out();
    t_level();
    t_edges();
    t_clear_race();
    t_mask();
    t_holes();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule